// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave-only serial port that lets an external host read and write a space of 16-bit configuration registers. The host owns an active-low enable, a serial clock that idles low, and a data line. Each frame is 32 serial clocks long. The first bit is a command bit (1 = write, 0 = read). The next 15 bits are a register address, and the last 16 bits are the data word. All fields are sent MSB first. The host may send any number of frames while the enable stays low.

All three serial inputs are brought into the system clock domain through two-flop synchronizers, and edges of the serial clock are detected there. The serial clock must therefore be at least about eight times slower than the system clock.

On the register side, a write produces a one-cycle strobe together with a held address and data word. A read produces a one-cycle read strobe when the instruction ends. The bus must answer on `reg_rdata` in that same cycle.

Address 0 is served by the port itself. It holds a local configuration word whose reset value is 0x001F. Bit 0 of that word picks the wire mode:
- 1 selects 4-wire mode, where read data leaves on `sdo`.
- 0 selects 3-wire mode, where read data is driven back on the shared data pin, with `sdio_oe` controlling its tristate buffer.

Top module: `spi_reg_port`

## Requirements
- R1: Input bits are captured on rising serial clock edges while `sen_n` is low. A frame is {cmd, addr[14:0], data[15:0]}, MSB first. A write frame to a nonzero address presents that address on `reg_addr` and that data on `reg_wdata`.
- R2: Each completed write frame to a nonzero address raises `reg_wr` for exactly one system clock cycle, a few cycles after the 32nd rising edge.
- R3: A read frame to a nonzero address raises `reg_rd` for one cycle after the 16th rising edge. In 4-wire mode, the `reg_rdata` value is returned on `sdo` MSB first. Each bit is valid at the rising edge where the host samples it (edges 17 to 32), and the bit advances only after falling edges.
- R4: In 3-wire mode (config bit 0 = 0), read data is driven on `sdio_out`. `sdio_oe` is high only across the 16 data bits of a read frame, and `sdo` stays 0.
- R5: Frames sent back to back while `sen_n` stays low are each decoded correctly.
- R6: When `sen_n` goes high in the middle of a frame, the partial frame is discarded with no strobe. The next frame starts from bit 0.
- R7: After reset, address 0 reads 0x001F and the port is in 4-wire mode.
- R8: Writes to address 0 update the local configuration word. Reads of address 0 return it. Neither kind of access produces `reg_wr` or `reg_rd`.
- R9: `sdio_oe` is low and `sdo` is 0 whenever no read data phase is in progress, including while `sen_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen_n | input | 1 | Serial enable from host, active low |
| sclk | input | 1 | Serial clock from host, idle low |
| sdio_in | input | 1 | Data pin input path (host to port) |
| sdio_out | output | 1 | Data pin output path, used in 3-wire mode |
| sdio_oe | output | 1 | Tristate enable for the shared data pin |
| sdo | output | 1 | Separate read data output, used in 4-wire mode |
| reg_addr | output | 15 | Register address of the current frame |
| reg_wdata | output | 16 | Write data, held after a write |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, sampled in the `reg_rd` cycle |

## Verification
The assertions check on every cycle that:
- both strobes last a single cycle and never coincide;
- `sdo` is silent while the shared pin is driven;
- nothing is driven or strobed after the enable has been high for a few cycles.

Only the bench scenarios can show the following:
- the frame decoding and the MSB-first read data on the pin that belongs to the current mode;
- the exact 16-bit drive window in 3-wire mode;
- the local handling of address 0 and the mode switch;
- the recovery from an aborted frame.

// File: rtl/spi_reg_port.sv
`timescale 1ns/1ps
module spi_reg_port #(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter logic [15:0] CFG_RST = 16'h001F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sen_n,
  input  logic          sclk,
  input  logic          sdio_in,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic          sdo,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  localparam int IW = AW + 1;
  localparam int FL = IW + DW;
  localparam int CW = $clog2(FL);

  logic [2:0]    sclk_s;
  logic [1:0]    sen_s, din_s;
  logic [CW-1:0] cnt;
  logic [IW-1:0] instr;
  logic [DW-1:0] dsr, out_sr, cfg;
  logic          rd_load, rd_act;

  wire rise     = sclk_s[1] & ~sclk_s[2];
  wire fall     = ~sclk_s[1] & sclk_s[2];
  wire active   = ~sen_s[1];
  wire din      = din_s[1];
  wire addr0    = (instr[AW-1:0] == '0);
  wire four_w   = cfg[0];
  wire last_bit = (cnt == CW'(FL-1));

  assign reg_addr = instr[AW-1:0];
  assign reg_rd   = rd_load & ~addr0;
  assign sdio_out = out_sr[DW-1];
  assign sdio_oe  = rd_act & ~four_w;
  assign sdo      = rd_act & four_w & out_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      sen_s  <= '1;
      din_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      sen_s  <= {sen_s[0], sen_n};
      din_s  <= {din_s[0], sdio_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      instr     <= '0;
      dsr       <= '0;
      out_sr    <= '0;
      cfg       <= CFG_RST[DW-1:0];
      rd_load   <= 1'b0;
      rd_act    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr  <= 1'b0;
      rd_load <= 1'b0;
      if (!active) begin
        cnt    <= '0;
        rd_act <= 1'b0;
      end else begin
        if (rise) begin
          cnt <= last_bit ? '0 : cnt + 1'b1;
          if (cnt < CW'(IW)) instr <= {instr[IW-2:0], din};
          else               dsr   <= {dsr[DW-2:0], din};
          if (cnt == CW'(IW-1)) rd_load <= ~instr[IW-2];
          if (last_bit) begin
            rd_act <= 1'b0;
            if (instr[IW-1]) begin
              if (addr0) cfg <= {dsr[DW-2:0], din};
              else begin
                reg_wr    <= 1'b1;
                reg_wdata <= {dsr[DW-2:0], din};
              end
            end
          end
        end
        if (rd_load) begin
          out_sr <= addr0 ? cfg : reg_rdata;
          rd_act <= 1'b1;
        end else if (fall && rd_act && cnt > CW'(IW)) begin
          out_sr <= {out_sr[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_port_chk.sv
`timescale 1ns/1ps
module spi_reg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sen_n,
  input logic sdo,
  input logic sdio_oe,
  input logic reg_wr,
  input logic reg_rd
);
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  p_sdo_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !sdo);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_n && $past(sen_n) && $past(sen_n, 2) && $past(sen_n, 3))
      |-> (!sdio_oe && !sdo && !reg_wr && !reg_rd));
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sdo(sdo),
  .sdio_oe(sdio_oe), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/tb_spi_reg_port.sv
`timescale 1ns/1ps
module tb_spi_reg_port;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sen_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, reg_wr, reg_rd;
  logic [14:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
  logic [14:0] last_a;
  logic [15:0] last_d;
  logic [15:0] cfg_model = 16'h001F;

  always #4 clk = ~clk;

  function automatic logic [15:0] bus_val(input logic [14:0] a);
    return {a[6:0], ~a[14:6]} ^ 16'hA5C3;
  endfunction

  assign reg_rdata = bus_val(reg_addr);

  spi_reg_port dut (
    .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin wr_cnt++; last_a <= reg_addr; last_d <= reg_wdata; end
    if (reg_rd) rd_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends 'nbits' bits of {cmd,addr,data}; collects read data and oe behaviour.
  task automatic frame(input bit wr, input logic [14:0] a, input logic [15:0] d, input int nbits,
                       output logic [15:0] r_sdo, output logic [15:0] r_sdio,
                       output int oe_hi, output int oe_bad, output int sdo_hi);
    logic [31:0] word;
    word = {wr, a, d};
    r_sdo = '0; r_sdio = '0; oe_hi = 0; oe_bad = 0; sdo_hi = 0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdio_in = word[31-i];
      wait_clk(HALF);
      if (i >= 16) begin
        r_sdo[31-i] = sdo;
        r_sdio[31-i] = sdio_out;
        if (sdio_oe) oe_hi++;
        if (sdo) sdo_hi++;
      end else if (sdio_oe) oe_bad++;
      sclk = 1'b1;
      wait_clk(HALF);
    end
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [15:0] d, input bit drop_sen);
    logic [15:0] x1, x2; int h, b, s, w0;
    w0 = wr_cnt;
    if (sen_n) begin sen_n = 1'b0; wait_clk(4); end
    frame(1'b1, a, d, 32, x1, x2, h, b, s);
    if (a == 0) begin
      cfg_model = d;
      chk(wr_cnt == w0, "R8 no strobe for addr0 write", wr_cnt - w0, 0);
    end else begin
      chk(wr_cnt == w0 + 1, "R2 one write strobe", wr_cnt - w0, 1);
      chk(last_a == a && last_d == d, "R1 write addr/data", {1'b0, last_a, last_d}, {1'b0, a, d});
    end
    if (drop_sen) begin sen_n = 1'b1; wait_clk(6); end
  endtask

  task automatic do_read(input logic [14:0] a, input bit drop_sen);
    logic [15:0] r4, r3, exp; int h, b, s, r0;
    r0 = rd_cnt;
    exp = (a == 0) ? cfg_model : bus_val(a);
    if (sen_n) begin sen_n = 1'b0; wait_clk(4); end
    frame(1'b0, a, 16'h0000, 32, r4, r3, h, b, s);
    if (a == 0) chk(rd_cnt == r0, "R8 no read strobe for addr0", rd_cnt - r0, 0);
    else        chk(rd_cnt == r0 + 1, "R3 one read strobe", rd_cnt - r0, 1);
    if (cfg_model[0]) begin
      chk(r4 == exp, "R3 4-wire read data on sdo", r4, exp);
      chk(h == 0 && b == 0, "R3 no pin drive in 4-wire", h + b, 0);
    end else begin
      chk(r3 == exp, "R4 3-wire read data on sdio", r3, exp);
      chk(h == 16 && b == 0, "R4 oe window is 16 data bits", h, 16);
      chk(s == 0, "R4 sdo quiet in 3-wire", s, 0);
    end
    chk(!sdio_oe && !sdo, "R9 released after data phase", {sdio_oe, sdo}, 0);
    if (drop_sen) begin sen_n = 1'b1; wait_clk(6); end
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] x1, x2; int h, b, s, w0;
    void'($urandom(32'h5EED1234));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    chk(!reg_wr && !reg_rd && !sdio_oe && !sdo, "R9 reset outputs idle",
        {reg_wr, reg_rd, sdio_oe, sdo}, 0);
    do_read(15'h0000, 1'b1);
    chk(cfg_model == 16'h001F, "R7 reset config", cfg_model, 16'h001F);

    // directed corners in 4-wire mode
    do_write(15'h7FFF, 16'hFFFF, 1'b1);
    do_write(15'h0001, 16'h0000, 1'b1);
    do_read(15'h7FFF, 1'b1);
    do_read(15'h0001, 1'b1);

    // R5: back-to-back frames under one enable
    for (int i = 0; i < 6; i++) begin
      logic [14:0] a;
      a = 15'($urandom) | 15'h1;
      if (i % 2 == 0) do_write(a, 16'($urandom), 1'b0);
      else            do_read(a, 1'b0);
    end
    sen_n = 1'b1; wait_clk(6);

    // random 4-wire traffic
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      a = 15'($urandom) | 15'h2;
      if ($urandom % 2) do_write(a, 16'($urandom), ($urandom % 3) == 0);
      else              do_read(a, ($urandom % 3) == 0);
    end
    sen_n = 1'b1; wait_clk(6);

    // R6: abort mid-frame, then a clean frame
    w0 = wr_cnt;
    sen_n = 1'b0; wait_clk(4);
    frame(1'b1, 15'h1234, 16'hBEEF, 20, x1, x2, h, b, s);
    sen_n = 1'b1; wait_clk(10);
    chk(wr_cnt == w0, "R6 aborted frame gives no strobe", wr_cnt - w0, 0);
    do_write(15'h0ABC, 16'h1357, 1'b1);
    w0 = wr_cnt;
    sen_n = 1'b0; wait_clk(4);
    frame(1'b0, 15'h0055, 16'h0, 17, x1, x2, h, b, s);
    sen_n = 1'b1; wait_clk(10);
    chk(!sdio_oe && !sdo, "R6 R9 abort during read releases pins", {sdio_oe, sdo}, 0);
    do_read(15'h0055, 1'b1);

    // R8: switch to 3-wire through address 0
    do_write(15'h0000, 16'h001E, 1'b1);
    do_read(15'h0000, 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic [14:0] a;
      a = 15'($urandom) | 15'h4;
      if ($urandom % 2) do_write(a, 16'($urandom), ($urandom % 2) == 0);
      else              do_read(a, ($urandom % 2) == 0);
    end
    sen_n = 1'b1; wait_clk(6);
    do_write(15'h0000, 16'hC3A5, 1'b1);
    do_read(15'h0000, 1'b1);
    do_read(15'h0321, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule